// File: doc/BRIEF.md
# Per-Privilege Interrupt Control Decoder

This block sits after interrupt arbitration. It takes the 8-bit control byte of the interrupt that has already won and works out which privilege mode takes it. It also splits the bits that are left into an interrupt level, a priority and a selective-vectoring flag. Each privilege mode owns a configuration byte. The delegation bits in the machine and supervisor bytes decide how many of the top control bits act as mode selectors. The byte of the receiving mode then decides how the remaining bits divide into level, priority and vectoring flag.

Software reads and writes the configuration bytes through a small access port. The port names a region and a byte offset within it. The machine region shows all three bytes, the supervisor region shows the supervisor and user bytes, and the user region shows only the user byte. The parameter `PRIV_SET` sets which modes the hart has: 0 for machine only, 1 for machine plus user, 2 for machine, supervisor and user. The configuration bytes are the only state. The decode path is purely combinational.

Top module: `intctl_priv_decode`

## Requirements
- R1: After a synchronous active-high reset, all three configuration bytes hold zero and every read returns 0x00.
- R2: The machine and supervisor bytes use this layout: bits 7:6 always read 0, bit 5 is delegation-enable, bits 4:1 are level-width and bit 0 is vectoring-enable. Implemented fields read back exactly as written.
- R3: In the user byte, bits 7:5 always read 0, bits 4:1 are level-width and bit 0 is vectoring-enable.
- R4: While machine delegation-enable is 0, the target is machine mode (privilege code 2'b11) and all 8 control bits form the level/priority field, whatever the supervisor and user bytes hold.
- R5: While machine delegation-enable is 1, control bit 7 set to 1 selects machine mode with a 7-bit field. Bit 7 set to 0 selects the next lower mode with a 7-bit field: user (code 2'b00) when PRIV_SET=1, supervisor when PRIV_SET=2.
- R6: With PRIV_SET=2, machine delegation 1, supervisor delegation 0 and bit 7 at 0, the target is supervisor (code 2'b01) with a 7-bit field, and the user byte has no effect.
- R7: With PRIV_SET=2, both delegation bits at 1 and bit 7 at 0, bit 6 set to 1 selects supervisor and bit 6 set to 0 selects user, each with a 6-bit field.
- R8: The level output is 8 bits. It takes the top n bits of the field, left-aligned, with all lower bits set to 1. Here n is the target mode's level-width, capped at the number of field bits left after any vectoring bit.
- R9: The priority output is 8 bits. It takes the field bits just below the level bits, down to and excluding the vectoring bit, left-aligned, with all lower bits set to 1.
- R10: When the target mode's vectoring-enable is 1, the vectoring flag equals field bit 0 and that bit is left out of the priority. When it is 0, the flag is 0.
- R11: The byte map is as follows. Region 0 has offset 0 = machine, 1 = supervisor, 2 = user. Region 1 has offset 0 = supervisor, 1 = user. Region 2 has offset 0 = user. Any other region/offset reads 0x00 and writes there change nothing.
- R12: Bytes of modes the hart lacks read 0x00 and ignore writes. A delegation-enable bit with no lower mode below it reads 0 and ignores writes: the machine bit when PRIV_SET=0, and the supervisor bit is absent with its byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_region | input | 2 | Access region: 0 machine, 1 supervisor, 2 user, 3 unmapped |
| cfg_addr | input | 2 | Byte offset inside the region |
| cfg_we | input | 1 | Write strobe for the addressed byte |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Addressed byte, combinational |
| ctl_in | input | 8 | Control byte of the winning interrupt |
| tgt_priv | output | 2 | Target mode: 2'b11 machine, 2'b01 supervisor, 2'b00 user |
| int_level | output | 8 | Decoded level, 1-filled |
| int_prio | output | 8 | Decoded priority, 1-filled |
| int_shv | output | 1 | Selective hardware vectoring flag |

## Verification
Two instances run side by side, one with three modes and one with machine and user only, so the same control byte must resolve to supervisor on one and to user on the other. Each control byte is swept through all 256 values under several delegation settings. This separates the bit-7 and bit-6 selector paths and the 8, 7 and 6 bit field widths. Level-width is swept from 0 to 15 with vectoring on and off, which exercises the capping of the level and the removal of the vectoring bit from the priority. Random register traffic, including writes to unmapped offsets and to reserved bits, tests the region map and the write masking.

// File: rtl/ipd_pkg.sv
package ipd_pkg;

    localparam int CTL_W = 8;
    localparam int IDX_W = $clog2(CTL_W);
    localparam int RW_W  = $clog2(CTL_W + 1);
    localparam int NLW_W = 4;
    localparam int NUM_BYTES = 3;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        SEL_M    = 2'd0,
        SEL_S    = 2'd1,
        SEL_U    = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic             dlg;
        logic [NLW_W-1:0] nlw;
        logic             ve;
    } cfg_fields_t;

    // Region/offset to byte select
    function automatic cfg_sel_e map_addr(input logic [1:0] region, input logic [1:0] addr);
        cfg_sel_e s;
        s = SEL_NONE;
        case (region)
            2'd0: if (addr <= 2'd2) s = cfg_sel_e'(addr);
            2'd1: begin
                if (addr == 2'd0) s = SEL_S;
                else if (addr == 2'd1) s = SEL_U;
            end
            2'd2: if (addr == 2'd0) s = SEL_U;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Whether byte i exists for a given privilege set
    function automatic bit byte_present(input int priv_set, input int i);
        if (i == 0) return 1'b1;
        if (i == 1) return priv_set == 2;
        return priv_set >= 1;
    endfunction

    // Whether byte i carries a writable delegation bit
    function automatic bit dlg_present(input int priv_set, input int i);
        if (i == 0) return priv_set >= 1;
        if (i == 1) return priv_set == 2;
        return 1'b0;
    endfunction

    function automatic logic [CTL_W-1:0] pack_cfg(input cfg_fields_t f);
        return {2'b00, f.dlg, f.nlw, f.ve};
    endfunction

endpackage

// File: rtl/ipd_cfg_regs.sv
module ipd_cfg_regs
    import ipd_pkg::*;
#(
    parameter int PRIV_SET = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       region,
    input  logic [1:0]       addr,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] rdata,
    output cfg_fields_t      m_cfg,
    output cfg_fields_t      s_cfg,
    output cfg_fields_t      u_cfg
);

    cfg_sel_e    sel;
    cfg_fields_t bytes_q [NUM_BYTES];

    assign sel = map_addr(region, addr);

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        localparam bit PRESENT = byte_present(PRIV_SET, i);
        localparam bit DLG_OK  = dlg_present(PRIV_SET, i);
        if (PRESENT) begin : g_impl
            cfg_fields_t q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (we && (sel == cfg_sel_e'(i))) begin
                    q.dlg <= DLG_OK & wdata[5];
                    q.nlw <= wdata[4:1];
                    q.ve  <= wdata[0];
                end
            end
            assign bytes_q[i] = q;
        end else begin : g_absent
            assign bytes_q[i] = '0;
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_M:   rdata = pack_cfg(bytes_q[0]);
            SEL_S:   rdata = pack_cfg(bytes_q[1]);
            SEL_U:   rdata = pack_cfg(bytes_q[2]);
            default: rdata = '0;
        endcase
    end

    assign m_cfg = bytes_q[0];
    assign s_cfg = bytes_q[1];
    assign u_cfg = bytes_q[2];

endmodule

// File: rtl/ipd_mode_select.sv
module ipd_mode_select
    import ipd_pkg::*;
#(
    parameter int PRIV_SET = 2
) (
    input  logic [CTL_W-1:0] ctl,
    input  cfg_fields_t      m_cfg,
    input  cfg_fields_t      s_cfg,
    input  cfg_fields_t      u_cfg,
    output priv_e            tgt,
    output logic [RW_W-1:0]  rem_w,
    output cfg_fields_t      sel_cfg
);

    localparam logic [RW_W-1:0] W_FULL = RW_W'(CTL_W);
    localparam logic [RW_W-1:0] W_ONE  = RW_W'(CTL_W - 1);
    localparam logic [RW_W-1:0] W_TWO  = RW_W'(CTL_W - 2);

    always_comb begin
        tgt     = PRIV_M;
        rem_w   = W_FULL;
        sel_cfg = m_cfg;
        if (m_cfg.dlg) begin
            rem_w = W_ONE;
            if (ctl[CTL_W-1]) begin
                tgt     = PRIV_M;
                sel_cfg = m_cfg;
            end else if (PRIV_SET == 1) begin
                tgt     = PRIV_U;
                sel_cfg = u_cfg;
            end else if (!s_cfg.dlg) begin
                tgt     = PRIV_S;
                sel_cfg = s_cfg;
            end else begin
                rem_w = W_TWO;
                if (ctl[CTL_W-2]) begin
                    tgt     = PRIV_S;
                    sel_cfg = s_cfg;
                end else begin
                    tgt     = PRIV_U;
                    sel_cfg = u_cfg;
                end
            end
        end
    end

endmodule

// File: rtl/ipd_field_split.sv
module ipd_field_split
    import ipd_pkg::*;
(
    input  logic [CTL_W-1:0] ctl,
    input  logic [RW_W-1:0]  rem_w,
    input  cfg_fields_t      cfg,
    output logic [CTL_W-1:0] lvl,
    output logic [CTL_W-1:0] prio,
    output logic             shv
);

    always_comb begin
        int avail;
        int nlc;
        int pcnt;
        int idx;
        avail = int'(rem_w) - int'(cfg.ve);
        nlc   = (int'(cfg.nlw) < avail) ? int'(cfg.nlw) : avail;
        pcnt  = avail - nlc;
        lvl   = '1;
        prio  = '1;
        for (int k = 0; k < CTL_W; k++) begin
            idx = int'(rem_w) - 1 - k;
            if (k < nlc) lvl[CTL_W-1-k] = ctl[idx[IDX_W-1:0]];
            idx = int'(rem_w) - 1 - nlc - k;
            if (k < pcnt) prio[CTL_W-1-k] = ctl[idx[IDX_W-1:0]];
        end
        shv = cfg.ve & ctl[0];
    end

endmodule

// File: rtl/intctl_priv_decode.sv
module intctl_priv_decode
    import ipd_pkg::*;
#(
    parameter int PRIV_SET = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_region,
    input  logic [1:0] cfg_addr,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic [7:0] ctl_in,
    output logic [1:0] tgt_priv,
    output logic [7:0] int_level,
    output logic [7:0] int_prio,
    output logic       int_shv
);

    cfg_fields_t     m_cfg_w;
    cfg_fields_t     s_cfg_w;
    cfg_fields_t     u_cfg_w;
    cfg_fields_t     sel_cfg_w;
    priv_e           tgt_w;
    logic [RW_W-1:0] rem_w_w;

    ipd_cfg_regs #(.PRIV_SET(PRIV_SET)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .region (cfg_region),
        .addr   (cfg_addr),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .m_cfg  (m_cfg_w),
        .s_cfg  (s_cfg_w),
        .u_cfg  (u_cfg_w)
    );

    ipd_mode_select #(.PRIV_SET(PRIV_SET)) u_sel (
        .ctl     (ctl_in),
        .m_cfg   (m_cfg_w),
        .s_cfg   (s_cfg_w),
        .u_cfg   (u_cfg_w),
        .tgt     (tgt_w),
        .rem_w   (rem_w_w),
        .sel_cfg (sel_cfg_w)
    );

    ipd_field_split u_split (
        .ctl   (ctl_in),
        .rem_w (rem_w_w),
        .cfg   (sel_cfg_w),
        .lvl   (int_level),
        .prio  (int_prio),
        .shv   (int_shv)
    );

    assign tgt_priv = tgt_w;

endmodule

// File: rtl/ipd_checker.sv
module ipd_checker
    import ipd_pkg::*;
#(
    parameter int PRIV_SET = 2
) (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  cfg_region,
    input logic [1:0]  cfg_addr,
    input logic        cfg_we,
    input logic [7:0]  cfg_rdata,
    input logic [7:0]  ctl_in,
    input logic [1:0]  tgt_priv,
    input logic        int_shv,
    input cfg_fields_t m_cfg,
    input cfg_fields_t s_cfg,
    input cfg_fields_t u_cfg,
    input cfg_fields_t sel_cfg
);

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[7:6] == 2'b00);

    assert_nodlg_m_R4: assert property (@(posedge clk) disable iff (rst)
        !m_cfg.dlg |-> tgt_priv == 2'b11);

    assert_top_bit_m_R5: assert property (@(posedge clk) disable iff (rst)
        ctl_in[7] |-> tgt_priv == 2'b11);

    assert_nodlg_s_R6: assert property (@(posedge clk) disable iff (rst)
        (m_cfg.dlg && !s_cfg.dlg && !ctl_in[7] && PRIV_SET == 2) |-> tgt_priv == 2'b01);

    assert_novec_R10: assert property (@(posedge clk) disable iff (rst)
        !sel_cfg.ve |-> !int_shv);

    assert_unmapped_write_R11: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && map_addr(cfg_region, cfg_addr) == SEL_NONE)
        |=> ($stable(m_cfg) && $stable(s_cfg) && $stable(u_cfg)));

    if (PRIV_SET != 2) begin : g_no_s
        assert_no_s_target_R12: assert property (@(posedge clk) disable iff (rst)
            tgt_priv != 2'b01);
    end

endmodule

bind intctl_priv_decode ipd_checker #(.PRIV_SET(PRIV_SET)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_region (cfg_region),
    .cfg_addr   (cfg_addr),
    .cfg_we     (cfg_we),
    .cfg_rdata  (cfg_rdata),
    .ctl_in     (ctl_in),
    .tgt_priv   (tgt_priv),
    .int_shv    (int_shv),
    .m_cfg      (m_cfg_w),
    .s_cfg      (s_cfg_w),
    .u_cfg      (u_cfg_w),
    .sel_cfg    (sel_cfg_w)
);

// File: tb/sim_intctl_priv_decode.sv
`timescale 1ns/1ps
module sim_intctl_priv_decode;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] cfg_region;
    logic [1:0] cfg_addr;
    logic       cfg_we;
    logic [7:0] cfg_wdata;
    logic [7:0] ctl_in;
    logic [7:0] rd0, rd1, lv0, lv1, pr0, pr1;
    logic [1:0] tp0, tp1;
    logic       sv0, sv1;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    bit rst_phase = 1'b0;
    int cfg0 [3];
    int cfg1 [3];

    always #2 clk = ~clk;

    intctl_priv_decode #(.PRIV_SET(2)) u0 (
        .clk(clk), .rst(rst), .cfg_region(cfg_region), .cfg_addr(cfg_addr),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(rd0), .ctl_in(ctl_in),
        .tgt_priv(tp0), .int_level(lv0), .int_prio(pr0), .int_shv(sv0));

    intctl_priv_decode #(.PRIV_SET(1)) u1 (
        .clk(clk), .rst(rst), .cfg_region(cfg_region), .cfg_addr(cfg_addr),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(rd1), .ctl_in(ctl_in),
        .tgt_priv(tp1), .int_level(lv1), .int_prio(pr1), .int_shv(sv1));

    function automatic int wmask(int ps, int b);
        if (b == 0) return (ps == 0) ? 'h1F : 'h3F;
        if (b == 1) return (ps == 2) ? 'h3F : 0;
        return (ps >= 1) ? 'h1F : 0;
    endfunction

    function automatic int byte_of(int rg, int a);
        if (rg == 0) return (a <= 2) ? a : 3;
        if (rg == 1) return (a == 0) ? 1 : ((a == 1) ? 2 : 3);
        if (rg == 2) return (a == 0) ? 2 : 3;
        return 3;
    endfunction

    function automatic void model(input int ps, input int mc, input int sc, input int uc,
                                  input int ctl, output int mode, output int lv,
                                  output int pr, output int sv, output string tag);
        int w, c, nl, ve, avail, nlc, pc, r;
        if (((mc >> 5) & 1) == 0) begin mode = 3; w = 8; c = mc; tag = "R4"; end
        else if (((ctl >> 7) & 1) == 1) begin mode = 3; w = 7; c = mc; tag = "R5"; end
        else if (ps == 1) begin mode = 0; w = 7; c = uc; tag = "R5"; end
        else if (((sc >> 5) & 1) == 0) begin mode = 1; w = 7; c = sc; tag = "R6"; end
        else if (((ctl >> 6) & 1) == 1) begin mode = 1; w = 6; c = sc; tag = "R7"; end
        else begin mode = 0; w = 6; c = uc; tag = "R7"; end
        nl = (c >> 1) & 15;
        ve = c & 1;
        avail = w - ve;
        nlc = (nl < avail) ? nl : avail;
        pc = avail - nlc;
        r = ctl & ((1 << w) - 1);
        lv = (((r >> (w - nlc)) & ((1 << nlc) - 1)) << (8 - nlc)) | ((1 << (8 - nlc)) - 1);
        pr = (((r >> ve) & ((1 << pc) - 1)) << (8 - pc)) | ((1 << (8 - pc)) - 1);
        sv = ve & r & 1;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_one(int ps, int mc, int sc, int uc, int rd, int tp, int lv, int pr, int sv);
        int em, el, ep, es, b, er;
        string tag, rtag;
        model(ps, mc, sc, uc, int'(ctl_in), em, el, ep, es, tag);
        b = byte_of(int'(cfg_region), int'(cfg_addr));
        er = (b == 0) ? mc : (b == 1) ? sc : (b == 2) ? uc : 0;
        if (rst_phase) rtag = "R1";
        else if (b == 3) rtag = "R11";
        else if (wmask(ps, b) == 0) rtag = "R12";
        else if (b == 2) rtag = "R3";
        else rtag = "R2";
        chk(rtag, $sformatf("rdata ps%0d", ps), rd, er);
        chk(tag, $sformatf("mode ps%0d ctl %0h", ps, ctl_in), tp, em);
        chk("R8", $sformatf("level ps%0d ctl %0h", ps, ctl_in), lv, el);
        chk("R9", $sformatf("prio ps%0d ctl %0h", ps, ctl_in), pr, ep);
        chk("R10", $sformatf("shv ps%0d ctl %0h", ps, ctl_in), sv, es);
    endtask

    task automatic cyc(int rg, int a, bit we, int wd, int ctl);
        int b;
        cfg_region = 2'(rg);
        cfg_addr   = 2'(a);
        cfg_we     = we;
        cfg_wdata  = 8'(wd);
        ctl_in     = 8'(ctl);
        @(posedge clk);
        if (rst) begin
            foreach (cfg0[i]) begin cfg0[i] = 0; cfg1[i] = 0; end
        end else if (we) begin
            b = byte_of(rg, a);
            if (b != 3) begin
                cfg0[b] = wd & wmask(2, b);
                cfg1[b] = wd & wmask(1, b);
            end
        end
        @(negedge clk);
        check_one(2, cfg0[0], cfg0[1], cfg0[2], int'(rd0), int'(tp0), int'(lv0), int'(pr0), int'(sv0));
        check_one(1, cfg1[0], cfg1[1], cfg1[2], int'(rd1), int'(tp1), int'(lv1), int'(pr1), int'(sv1));
    endtask

    task automatic wr(int rg, int a, int wd);
        cyc(rg, a, 1'b1, wd, 0);
    endtask

    task automatic sweep_ctl();
        for (int c = 0; c < 256; c++) cyc(0, 3, 1'b0, 0, c);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        rst_phase = 1'b1;
        cyc(0, 0, 1'b1, 'hFF, 'h5A);
        cyc(0, 1, 1'b0, 0, 'hA5);
        rst = 1'b0;
        // R1: every mapped byte reads zero after reset
        for (int rg = 0; rg < 4; rg++)
            for (int a = 0; a < 4; a++) cyc(rg, a, 1'b0, 0, rg * 16 + a);
        rst_phase = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        cfg_region = '0; cfg_addr = '0; cfg_we = 1'b0; cfg_wdata = '0; ctl_in = '0;
        foreach (cfg0[i]) begin cfg0[i] = 0; cfg1[i] = 0; end
        @(negedge clk);
        do_reset();

        // R4: no delegation, S/U bytes loaded but ignored
        wr(0, 1, 'h2B); wr(0, 2, 'h17);
        sweep_ctl();
        // R2/R3/R12: all-ones writes through every region
        for (int rg = 0; rg < 4; rg++)
            for (int a = 0; a < 4; a++) begin
                wr(rg, a, 'hFF);
                cyc(rg, a, 1'b0, 0, 'h3C);
            end
        // R5/R7/R8/R9/R10: level-width and vectoring sweeps
        for (int nl = 0; nl < 16; nl++)
            for (int ve = 0; ve < 2; ve++) begin
                wr(0, 0, 'h20 | (nl << 1) | ve);
                wr(1, 0, 'h20 | (((nl + 3) % 16) << 1) | (ve ^ 1));
                wr(2, 0, (((15 - nl)) << 1) | ve);
                for (int k = 0; k < 24; k++) cyc(0, k % 3, 1'b0, 0, $urandom_range(0, 255));
            end
        // R6: supervisor delegation off
        wr(0, 0, 'h27); wr(1, 0, 'h09); wr(2, 0, 'h1F);
        sweep_ctl();
        // R7: both delegations on
        wr(1, 0, 'h25);
        sweep_ctl();
        // R11: random traffic including unmapped offsets
        for (int k = 0; k < 2000; k++)
            cyc($urandom_range(0, 3), $urandom_range(0, 3), ($urandom_range(0, 9) < 3),
                $urandom_range(0, 255), $urandom_range(0, 255));
        // R1: reset mid-run clears programmed bytes
        do_reset();
        sweep_ctl();

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule